// File: doc/BRIEF.md
# Keyed System Control Register File

This block is the control and status register file of a processor core module. A simple register bus reaches it through a word index, which is the byte offset divided by four. The block returns fixed identity and status words. It holds two oscillator settings that accept writes only after a 16-bit unlock key has been stored, and a control word that drives a boot remap select and an LED. Setting the reset bit of the control word raises a self-clearing reset request.

Software sets and clears bits of two flag words through paired addresses. One flag word is cleared by any reset. The other survives the system reset that the reset request triggers and clears only on power-on reset. An SDRAM configuration word resets to a value that carries a size code derived from the `MEM_MB` parameter. The bus has valid, write, a word index and write data. Read data is registered and arrives one cycle after the read is accepted. An access to an index the block does not implement raises a one-cycle error strobe.

Top module: `coremod_ctrl_regs`

## Requirements
- R1: Index 0 reads 0x411A3001, index 1 reads 0 and index 4 reads 0x00100000. Writes to these indices change nothing. Read data appears on `busRdata` in the cycle after the read is accepted and holds until the next read.
- R2: A write to the lock index (5) stores bits 15:0 of the data. Reading index 5 returns 0x0001A05F while the stored value is 0xA05F, and returns the stored 16-bit value zero-extended otherwise.
- R3: Writes to the oscillator index (2) and the auxiliary oscillator index (7) update the register only while the lock holds 0xA05F. Otherwise they are dropped.
- R4: A write to the control index (3) updates only bits 0 and 2. All other bits, bit 3 included, read as zero.
- R5: A control write with bit 3 set makes `resetReq` high for exactly the one cycle after the write.
- R6: `ledOn` follows control bit 0 and `remapSel` follows control bit 2 (1 means RAM at address zero, 0 means boot flash at address zero). Both change in the cycle after the control write.
- R7: A write to index 12 ORs the data into the flags word and a write to index 13 clears the bits that are set in the data. Index 12 reads the flags word and index 13 reads zero.
- R8: Indices 14 (set) and 15 (clear) do the same for the nonvolatile flags word, which index 14 reads. This word keeps its value through `rstSysN` and clears only on `rstPorN`.
- R9: After either reset: oscillator 0x01000048, auxiliary oscillator 0x0007FEFF, init word (index 9) 0x00000112, and lock, control, flags and read data all zero.
- R10: The SDRAM word (index 8) resets to 0x00011122 ORed with a size code of 0x10 if `MEM_MB` >= 256, 0x0C if >= 128, 0x08 if >= 64, 0x04 if >= 32, and 0 otherwise. Indices 8 and 9 accept any write.
- R11: Indices 32 to 35 read zero, ignore writes and raise no error.
- R12: Any index not listed above reads zero and ignores writes. `busErr` is high for exactly the cycle after such an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstPorN | input | 1 | Synchronous power-on reset, active low; clears everything |
| rstSysN | input | 1 | Synchronous system reset, active low; clears all but the nonvolatile flags |
| busValid | input | 1 | Access request, accepted at the rising edge |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Word index |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| busErr | output | 1 | One-cycle strobe after an access to an unimplemented index |
| resetReq | output | 1 | One-cycle reset request pulse |
| remapSel | output | 1 | Boot remap select: 1 RAM at zero, 0 flash at zero |
| ledOn | output | 1 | LED drive |

## Verification
A write updates its register at the edge that accepts it. Read data and the error strobe are due one cycle after the accepting edge. `resetReq`, `remapSel` and `ledOn` change one cycle after the control write, and `resetReq` falls again one cycle later. The scoreboard stamps every expected item with the cycle count in which it is due, and the monitor compares each item at the falling edge of exactly that cycle. Lock-gated writes, reset survival of the nonvolatile flags, and the size code for two values of `MEM_MB` are each checked by reading back through the bus.

// File: rtl/coremod_ctrl_pkg.sv
package coremod_ctrl_pkg;

  localparam int DATA_W = 32;

  // word indices with fixed meaning
  localparam int IDX_ID        = 0;
  localparam int IDX_PROC      = 1;
  localparam int IDX_OSC       = 2;
  localparam int IDX_CTRL      = 3;
  localparam int IDX_STAT      = 4;
  localparam int IDX_LOCK      = 5;
  localparam int IDX_AUX       = 7;
  localparam int IDX_SDRAM     = 8;
  localparam int IDX_INIT      = 9;
  localparam int IDX_FLAGS_SET = 12;
  localparam int IDX_FLAGS_CLR = 13;
  localparam int IDX_NV_SET    = 14;
  localparam int IDX_NV_CLR    = 15;
  localparam int IDX_VOLT_LO   = 32;
  localparam int IDX_VOLT_HI   = 35;

  localparam logic [DATA_W-1:0] ID_WORD    = 32'h411A_3001;
  localparam logic [DATA_W-1:0] STAT_WORD  = 32'h0010_0000;
  localparam logic [DATA_W-1:0] OSC_RST    = 32'h0100_0048;
  localparam logic [DATA_W-1:0] AUX_RST    = 32'h0007_FEFF;
  localparam logic [DATA_W-1:0] INIT_RST   = 32'h0000_0112;
  localparam logic [DATA_W-1:0] SDRAM_BASE = 32'h0001_1122;
  localparam logic [15:0]       UNLOCK_KEY = 16'hA05F;

  function automatic logic [DATA_W-1:0] sizeCode(input int mb);
    if (mb >= 256)      sizeCode = 32'h10;
    else if (mb >= 128) sizeCode = 32'h0C;
    else if (mb >= 64)  sizeCode = 32'h08;
    else if (mb >= 32)  sizeCode = 32'h04;
    else                sizeCode = 32'h00;
  endfunction

  // strobes from the decoder to the register storage
  typedef struct packed {
    logic rdEn;
    logic wrOsc;
    logic wrCtrl;
    logic wrLock;
    logic wrAux;
    logic wrSdram;
    logic wrInit;
    logic setFlags;
    logic clrFlags;
    logic setNv;
    logic clrNv;
  } regStrobeT;

endpackage

// File: rtl/coremod_ctrl_decode.sv
module coremod_ctrl_decode
  import coremod_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobeT         strb,
  output logic              errPulse
);

  logic known;
  logic doWr;

  assign doWr = busValid & busWrite;

  always_comb begin
    strb       = '0;
    strb.rdEn  = busValid & ~busWrite;
    known      = 1'b1;
    case (busAddr)
      ADDR_W'(IDX_ID), ADDR_W'(IDX_PROC), ADDR_W'(IDX_STAT): known = 1'b1;
      ADDR_W'(IDX_OSC):       strb.wrOsc    = doWr;
      ADDR_W'(IDX_CTRL):      strb.wrCtrl   = doWr;
      ADDR_W'(IDX_LOCK):      strb.wrLock   = doWr;
      ADDR_W'(IDX_AUX):       strb.wrAux    = doWr;
      ADDR_W'(IDX_SDRAM):     strb.wrSdram  = doWr;
      ADDR_W'(IDX_INIT):      strb.wrInit   = doWr;
      ADDR_W'(IDX_FLAGS_SET): strb.setFlags = doWr;
      ADDR_W'(IDX_FLAGS_CLR): strb.clrFlags = doWr;
      ADDR_W'(IDX_NV_SET):    strb.setNv    = doWr;
      ADDR_W'(IDX_NV_CLR):    strb.clrNv    = doWr;
      default:
        known = (busAddr >= ADDR_W'(IDX_VOLT_LO)) && (busAddr <= ADDR_W'(IDX_VOLT_HI));
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) errPulse <= 1'b0;
    else       errPulse <= busValid & ~known;
  end

  // R12
  err_after_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(busValid));

endmodule

// File: rtl/coremod_ctrl_store.sv
module coremod_ctrl_store
  import coremod_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int MEM_MB = 128
) (
  input  logic              clk,
  input  logic              rstPorN,
  input  logic              rstSysN,
  input  regStrobeT         strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              resetReq,
  output logic              remapSel,
  output logic              ledOn
);

  localparam logic [DATA_W-1:0] SDRAM_RST = SDRAM_BASE | sizeCode(MEM_MB);

  logic [DATA_W-1:0] oscQ, auxQ, sdramQ, initQ, flagsQ, nvQ, rdQ, rdNext;
  logic [15:0]       lockQ;
  logic              ledQ, remapQ, rstReqQ;
  logic              unlocked;
  logic              anyRstN;

  assign unlocked = (lockQ == UNLOCK_KEY);
  assign anyRstN  = rstPorN & rstSysN;

  always_ff @(posedge clk) begin
    if (!anyRstN) begin
      oscQ    <= OSC_RST;
      auxQ    <= AUX_RST;
      sdramQ  <= SDRAM_RST;
      initQ   <= INIT_RST;
      flagsQ  <= '0;
      lockQ   <= '0;
      ledQ    <= 1'b0;
      remapQ  <= 1'b0;
      rstReqQ <= 1'b0;
      rdQ     <= '0;
    end else begin
      if (strb.wrOsc && unlocked) oscQ <= busWdata;
      if (strb.wrAux && unlocked) auxQ <= busWdata;
      if (strb.wrSdram) sdramQ <= busWdata;
      if (strb.wrInit)  initQ  <= busWdata;
      if (strb.wrLock)  lockQ  <= busWdata[15:0];
      if (strb.setFlags)      flagsQ <= flagsQ | busWdata;
      else if (strb.clrFlags) flagsQ <= flagsQ & ~busWdata;
      if (strb.wrCtrl) begin
        ledQ   <= busWdata[0];
        remapQ <= busWdata[2];
      end
      rstReqQ <= strb.wrCtrl & busWdata[3] & ~rstReqQ;
      if (strb.rdEn) rdQ <= rdNext;
    end
  end

  // nonvolatile flags: only power-on reset clears them
  always_ff @(posedge clk) begin
    if (!rstPorN)        nvQ <= '0;
    else if (strb.setNv) nvQ <= nvQ | busWdata;
    else if (strb.clrNv) nvQ <= nvQ & ~busWdata;
  end

  always_comb begin
    case (busAddr)
      ADDR_W'(IDX_ID):        rdNext = ID_WORD;
      ADDR_W'(IDX_STAT):      rdNext = STAT_WORD;
      ADDR_W'(IDX_OSC):       rdNext = oscQ;
      ADDR_W'(IDX_CTRL):      rdNext = {29'd0, remapQ, 1'b0, ledQ};
      ADDR_W'(IDX_LOCK):      rdNext = {15'd0, unlocked, lockQ};
      ADDR_W'(IDX_AUX):       rdNext = auxQ;
      ADDR_W'(IDX_SDRAM):     rdNext = sdramQ;
      ADDR_W'(IDX_INIT):      rdNext = initQ;
      ADDR_W'(IDX_FLAGS_SET): rdNext = flagsQ;
      ADDR_W'(IDX_NV_SET):    rdNext = nvQ;
      default:                rdNext = '0;
    endcase
  end

  assign busRdata = rdQ;
  assign resetReq = rstReqQ;
  assign remapSel = remapQ;
  assign ledOn    = ledQ;

  // R3
  osc_locked_chk: assert property (@(posedge clk) disable iff (!anyRstN)
    !unlocked |=> $stable(oscQ));
  // R3
  aux_locked_chk: assert property (@(posedge clk) disable iff (!anyRstN)
    !unlocked |=> $stable(auxQ));
  // R5
  rst_req_pulse_chk: assert property (@(posedge clk) disable iff (!anyRstN)
    resetReq |=> !resetReq);
  // R6
  remap_hold_chk: assert property (@(posedge clk) disable iff (!anyRstN)
    !strb.wrCtrl |=> $stable(remapSel));
  // R4
  ctrl_bit3_chk: assert property (@(posedge clk) disable iff (!anyRstN)
    (strb.rdEn && busAddr == ADDR_W'(IDX_CTRL)) |=> (busRdata[3] == 1'b0));
  // R8
  nv_clear_chk: assert property (@(posedge clk) disable iff (!rstPorN)
    strb.clrNv |=> ((nvQ & $past(busWdata)) == '0));

endmodule

// File: rtl/coremod_ctrl_regs.sv
module coremod_ctrl_regs
  import coremod_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int MEM_MB = 128
) (
  input  logic              clk,
  input  logic              rstPorN,
  input  logic              rstSysN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busErr,
  output logic              resetReq,
  output logic              remapSel,
  output logic              ledOn
);

  regStrobeT strb;
  logic      anyRstN;

  assign anyRstN = rstPorN & rstSysN;

  coremod_ctrl_decode #(.ADDR_W(ADDR_W)) decodeU (
    .clk      (clk),
    .rstN     (anyRstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb),
    .errPulse (busErr)
  );

  coremod_ctrl_store #(.ADDR_W(ADDR_W), .MEM_MB(MEM_MB)) storeU (
    .clk      (clk),
    .rstPorN  (rstPorN),
    .rstSysN  (rstSysN),
    .strb     (strb),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .resetReq (resetReq),
    .remapSel (remapSel),
    .ledOn    (ledOn)
  );

endmodule

// File: tb/coremod_ctrl_regs_test.sv
module coremod_ctrl_regs_test;

  localparam int SEL_RD = 0, SEL_ERR = 1, SEL_RSTREQ = 2, SEL_REMAP = 3, SEL_LED = 4, SEL_RD_SMALL = 5;

  logic        clk = 1'b0;
  logic        rstPorN = 1'b0, rstSysN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata, busRdataSmall;
  logic        busErr, busErrSmall, resetReq, rrSmall, remapSel, remapSmall, ledOn, ledSmall;

  always #2 clk = ~clk;  // 250 MHz

  coremod_ctrl_regs uut (
    .clk(clk), .rstPorN(rstPorN), .rstSysN(rstSysN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr),
    .resetReq(resetReq), .remapSel(remapSel), .ledOn(ledOn));

  coremod_ctrl_regs #(.MEM_MB(40)) uutSmall (
    .clk(clk), .rstPorN(rstPorN), .rstSysN(rstSysN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdataSmall), .busErr(busErrSmall),
    .resetReq(rrSmall), .remapSel(remapSmall), .ledOn(ledSmall));

  typedef struct {
    int          due;
    int          sel;
    logic [31:0] exp;
    string       tag;
  } itemT;

  itemT sbq[$];
  int   cycleCnt = 0;
  int   lastIssue = 0;
  int   total = 0, bad = 0;
  bit   finished = 1'b0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic expectAt(input int due, input int sel, input logic [31:0] e, input string tag);
    itemT it;
    it.due = due; it.sel = sel; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic xfer(input bit w, input int idx, input logic [31:0] d);
    @(posedge clk); #1;
    busValid = 1'b1; busWrite = w; busAddr = 6'(idx); busWdata = d;
    lastIssue = cycleCnt;
    @(posedge clk); #1;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    xfer(1'b1, idx, d);
  endtask

  task automatic rd(input int idx, input logic [31:0] e, input string tag);
    xfer(1'b0, idx, '0);
    expectAt(lastIssue + 1, SEL_RD, e, tag);
  endtask

  function automatic logic [31:0] actual(input int sel);
    case (sel)
      SEL_RD:       return busRdata;
      SEL_ERR:      return {31'd0, busErr};
      SEL_RSTREQ:   return {31'd0, resetReq};
      SEL_REMAP:    return {31'd0, remapSel};
      SEL_LED:      return {31'd0, ledOn};
      default:      return busRdataSmall;
    endcase
  endfunction

  // monitor: compare every item in its due cycle
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cycleCnt) begin
      itemT it;
      logic [31:0] got;
      it  = sbq.pop_front();
      got = actual(it.sel);
      total++;
      if (it.due != cycleCnt || got !== it.exp) begin
        bad++;
        $display("FAIL %s: got %h exp %h (due %0d now %0d)", it.tag, got, it.exp, it.due, cycleCnt);
      end
    end
  end

  task automatic finish();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got %0d exp %0d cycles", cycleCnt, 20000);
      finish();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rstPorN = 1'b1; rstSysN = 1'b1;

    // reset state
    expectAt(cycleCnt + 1, SEL_REMAP, 0, "R9 remap after reset");
    expectAt(cycleCnt + 1, SEL_RSTREQ, 0, "R9 resetReq after reset");
    expectAt(cycleCnt + 1, SEL_RD, 0, "R9 rdata after reset");
    rd(0, 32'h411A_3001, "R1 id word");
    rd(1, 32'h0, "R1 proc word");
    rd(4, 32'h0010_0000, "R1 status word");
    rd(2, 32'h0100_0048, "R9 osc reset");
    rd(7, 32'h0007_FEFF, "R9 aux reset");
    rd(9, 32'h0000_0112, "R9 init reset");
    rd(8, 32'h0001_112E, "R10 sdram 128MB");
    expectAt(lastIssue + 1, SEL_RD_SMALL, 32'h0001_1126, "R10 sdram 40MB");
    rd(3, 32'h0, "R9 ctrl reset");
    rd(5, 32'h0, "R9 lock reset");
    rd(12, 32'h0, "R9 flags reset");
    rd(14, 32'h0, "R8 nv reset");

    // locked writes dropped
    wr(2, 32'hDEAD_BEEF);
    rd(2, 32'h0100_0048, "R3 osc locked");
    wr(7, 32'h1234_5678);
    rd(7, 32'h0007_FEFF, "R3 aux locked");

    // unlock
    wr(5, 32'h1234_A05F);
    rd(5, 32'h0001_A05F, "R2 lock read unlocked");
    wr(2, 32'h0200_0011);
    rd(2, 32'h0200_0011, "R3 osc unlocked");
    wr(7, 32'h0000_0055);
    rd(7, 32'h0000_0055, "R3 aux unlocked");
    wr(5, 32'hFFFF_A05E);
    rd(5, 32'h0000_A05E, "R2 lock read other");
    wr(2, 32'h0000_0001);
    rd(2, 32'h0200_0011, "R3 osc relocked");

    // control
    wr(3, 32'hFFFF_FFF7);
    expectAt(lastIssue + 1, SEL_REMAP, 1, "R6 remap set");
    expectAt(lastIssue + 1, SEL_LED, 1, "R6 led set");
    expectAt(lastIssue + 1, SEL_RSTREQ, 0, "R5 no request without bit3");
    rd(3, 32'h0000_0005, "R4 ctrl only bits 0,2");
    wr(3, 32'h0000_0004);
    expectAt(lastIssue + 1, SEL_LED, 0, "R6 led clear");
    expectAt(lastIssue + 1, SEL_REMAP, 1, "R6 remap kept");
    wr(3, 32'h0000_000C);
    expectAt(lastIssue + 1, SEL_RSTREQ, 1, "R5 request pulse");
    expectAt(lastIssue + 2, SEL_RSTREQ, 0, "R5 request clears");
    rd(3, 32'h0000_0004, "R4 bit3 reads zero");

    // flags
    wr(12, 32'h0000_F0F0);
    wr(12, 32'h0000_000F);
    rd(12, 32'h0000_F0FF, "R7 flags set");
    wr(13, 32'h0000_00F1);
    rd(12, 32'h0000_F00E, "R7 flags clear");
    rd(13, 32'h0, "R7 clear index reads zero");
    wr(14, 32'h0000_00A5);
    wr(15, 32'h0000_0005);
    rd(14, 32'h0000_00A0, "R8 nv set/clear");

    // free registers
    wr(8, 32'h1234_5678);
    rd(8, 32'h1234_5678, "R10 sdram writable");
    wr(9, 32'h0000_0009);
    rd(9, 32'h0000_0009, "R10 init writable");

    // voltage, read-only, unimplemented
    wr(33, 32'hFFFF_FFFF);
    expectAt(lastIssue + 1, SEL_ERR, 0, "R11 no error on voltage write");
    rd(33, 32'h0, "R11 voltage reads zero");
    wr(0, 32'h0);
    expectAt(lastIssue + 1, SEL_ERR, 0, "R1 no error on id write");
    rd(0, 32'h411A_3001, "R1 id after write");
    rd(6, 32'h0, "R12 unimplemented reads zero");
    expectAt(lastIssue + 1, SEL_ERR, 1, "R12 error strobe on read");
    expectAt(lastIssue + 2, SEL_ERR, 0, "R12 error strobe one cycle");
    wr(16, 32'hFFFF_FFFF);
    expectAt(lastIssue + 1, SEL_ERR, 1, "R12 error strobe on write");
    rd(12, 32'h0000_F00E, "R12 write ignored");
    rd(40, 32'h0, "R12 high index reads zero");

    // system reset keeps nonvolatile flags
    @(posedge clk); #1; rstSysN = 1'b0;
    repeat (2) @(posedge clk);
    #1; rstSysN = 1'b1;
    expectAt(cycleCnt + 1, SEL_REMAP, 0, "R9 remap after system reset");
    rd(14, 32'h0000_00A0, "R8 nv survives system reset");
    rd(12, 32'h0, "R9 flags cleared by system reset");
    rd(2, 32'h0100_0048, "R9 osc after system reset");
    rd(3, 32'h0, "R9 ctrl after system reset");

    // power-on reset clears them
    @(posedge clk); #1; rstPorN = 1'b0;
    repeat (2) @(posedge clk);
    #1; rstPorN = 1'b1;
    rd(14, 32'h0, "R8 nv cleared by power-on reset");

    repeat (4) @(posedge clk);
    if (sbq.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: got %0d exp %0d pending items", sbq.size(), 0);
    end
    finish();
  end

endmodule